// File: doc/BRIEF.md
# Temporary/Product Register Multiply Unit

This block is the multiply half of a fixed-point signal-processing datapath. It holds a 16-bit temporary operand register, a 32-bit product register and a 2-bit product shift mode. Each clock cycle it accepts one already-decoded operation, a 16-bit operand and the current 32-bit accumulator value. It can multiply signed or unsigned, multiply by a 13-bit signed immediate, or square the operand. Some operations also move the shifted product into the accumulator, or add it to or subtract it from the accumulator.

The accumulating forms make a software-pipelined multiply-accumulate. The product left by the previous operation is shifted, then added to or subtracted from the accumulator. In the same cycle a new temporary value is loaded or a new product is formed. The new accumulator value comes out one clock later with a write strobe, so the accumulator that owns it can capture it. Instruction fetch and operand addressing happen upstream of this block.

Top module: `tp_mul_unit`

## Requirements
- R1: After reset, `treg_o`, `preg_o`, `pmode_o`, `acc_o`, `acc_we_o` and `carry_o` are all zero.
- R2: Op codes 1, 2, 3, 4, 10 and 11 load `opnd_i` into the temporary register at the next clock edge. Every other op leaves the temporary register unchanged.
- R3: Op 5 writes the signed product of the temporary register and `opnd_i` into the product register. Op 6 multiplies the temporary register by `opnd_i[12:0]` sign-extended to 16 bits.
- R4: Op 9 writes the product of the temporary register and `opnd_i` into the product register, with both factors taken as unsigned.
- R5: Op 10 (square and add) and op 11 (square and subtract) each do three things at once:
  - load `opnd_i` into the temporary register;
  - write the signed square of `opnd_i` into the product register;
  - add (op 10) or subtract (op 11) the previous shifted product to or from the accumulator.
- R6: The accumulating ops always use the product register value from before the edge, shifted by the mode from before the edge. These ops are:
  - add: 2, 7, 10, 12;
  - subtract: 3, 8, 11, 13;
  - move: 4, 14.

  Ops 7 and 8 also write a new signed product of the temporary register and `opnd_i`.
- R7: The product shift applied before the accumulator depends on the mode:

  | Mode | Shift |
  |------|-------|
  | 0 | none |
  | 1 | left by 1 |
  | 2 | left by 4 |
  | 3 | arithmetic right by 6 |

  Left shifts drop the bits shifted out of bit 31.
- R8: Op 15 loads `opnd_i[1:0]` into the shift mode. No other op changes the mode.
- R9: After an accumulating op, `acc_we_o` is 1 in the following cycle, and `acc_o` holds the result: accumulator plus shifted product, accumulator minus shifted product, or the shifted product alone for a move. After any other op, `acc_we_o` is 0 and `acc_o` keeps its previous value.
- R10: When `sat_en_i` is 1, a signed overflow of an add or subtract gives 0x7FFFFFFF for positive overflow and 0x80000000 for negative overflow. When `sat_en_i` is 0, the result wraps modulo 2^32.
- R11: `carry_o` is set as follows:

  | Op kind | `carry_o` |
  |---------|-----------|
  | add | unsigned carry out of bit 31 |
  | subtract | 1 when there is no unsigned borrow |
  | move and non-accumulating ops | unchanged |

- R12: The product register keeps its value across every op other than 5, 6, 7, 8, 9, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Decoded operation code (0 = no operation) |
| opnd_i | input | 16 | Data or immediate operand |
| acc_i | input | 32 | Current accumulator value |
| sat_en_i | input | 1 | Saturate signed overflow of accumulator updates |
| acc_o | output | 32 | New accumulator value |
| acc_we_o | output | 1 | Accumulator write strobe for `acc_o` |
| carry_o | output | 1 | Carry / no-borrow from the last add or subtract |
| treg_o | output | 16 | Temporary register contents |
| preg_o | output | 32 | Product register contents |
| pmode_o | output | 2 | Product shift mode |

## Verification
The assertions assume that every input is a known value, captured at the rising edge. They also assume that the op code alone decides which registers may change. All sixteen codes are defined, so there is no illegal code to exclude. The stimulus changes all inputs only at the falling edge. It draws op codes, operands, accumulator values and the saturation enable from their full ranges. Directed sequences add the extreme factors (-32768 squared, 0xFFFF unsigned), every shift mode, and saturation at both ends of the accumulator range.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_LDT      = 4'd1,
        OP_LDT_ADD  = 4'd2,
        OP_LDT_SUB  = 4'd3,
        OP_LDT_MOVP = 4'd4,
        OP_MUL      = 4'd5,
        OP_MULI     = 4'd6,
        OP_MUL_ADD  = 4'd7,
        OP_MUL_SUB  = 4'd8,
        OP_MULU     = 4'd9,
        OP_SQR_ADD  = 4'd10,
        OP_SQR_SUB  = 4'd11,
        OP_ADDP     = 4'd12,
        OP_SUBP     = 4'd13,
        OP_MOVP     = 4'd14,
        OP_SETPM    = 4'd15
    } tpm_op_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_SUB  = 2'd2,
        ACC_MOV  = 2'd3
    } acc_fn_e;

    typedef struct packed {
        logic    ld_t;    // load temporary register
        logic    wr_p;    // write product register
        logic    sq;      // square: first factor is operand
        logic    imm;     // second factor is 13-bit immediate
        logic    uns;     // unsigned factors
        acc_fn_e acc;     // accumulator function
        logic    set_pm;  // load product shift mode
    } tpm_ctl_t;

    function automatic tpm_ctl_t tpm_decode(input logic [3:0] op);
        tpm_ctl_t c;
        c = '{ld_t: 1'b0, wr_p: 1'b0, sq: 1'b0, imm: 1'b0, uns: 1'b0,
              acc: ACC_NONE, set_pm: 1'b0};
        case (tpm_op_e'(op))
            OP_LDT:      c.ld_t = 1'b1;
            OP_LDT_ADD:  begin c.ld_t = 1'b1; c.acc = ACC_ADD; end
            OP_LDT_SUB:  begin c.ld_t = 1'b1; c.acc = ACC_SUB; end
            OP_LDT_MOVP: begin c.ld_t = 1'b1; c.acc = ACC_MOV; end
            OP_MUL:      c.wr_p = 1'b1;
            OP_MULI:     begin c.wr_p = 1'b1; c.imm = 1'b1; end
            OP_MUL_ADD:  begin c.wr_p = 1'b1; c.acc = ACC_ADD; end
            OP_MUL_SUB:  begin c.wr_p = 1'b1; c.acc = ACC_SUB; end
            OP_MULU:     begin c.wr_p = 1'b1; c.uns = 1'b1; end
            OP_SQR_ADD:  begin c.ld_t = 1'b1; c.wr_p = 1'b1; c.sq = 1'b1; c.acc = ACC_ADD; end
            OP_SQR_SUB:  begin c.ld_t = 1'b1; c.wr_p = 1'b1; c.sq = 1'b1; c.acc = ACC_SUB; end
            OP_ADDP:     c.acc = ACC_ADD;
            OP_SUBP:     c.acc = ACC_SUB;
            OP_MOVP:     c.acc = ACC_MOV;
            OP_SETPM:    c.set_pm = 1'b1;
            default:     ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tpm_mult.sv
module tpm_mult #(
    parameter int DW = 16,
    localparam int PW = 2 * DW
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          uns_i,
    output logic [PW-1:0] p_o
);
    logic signed [DW:0]   a_x;
    logic signed [DW:0]   b_x;
    logic signed [PW+1:0] full;

    always_comb begin
        a_x  = {(uns_i ? 1'b0 : a_i[DW-1]), a_i};
        b_x  = {(uns_i ? 1'b0 : b_i[DW-1]), b_i};
        full = a_x * b_x;
        p_o  = full[PW-1:0];
    end

    // R3: a zero factor gives a zero product in any mode
    always_comb begin
        if (b_i == '0) begin
            assert_zero_factor_R3: assert (p_o == '0);
        end
    end

endmodule

// File: rtl/tpm_pshift.sv
module tpm_pshift #(
    parameter int PW  = 32,
    parameter int SL1 = 1,
    parameter int SL2 = 4,
    parameter int SR  = 6
) (
    input  logic [PW-1:0] p_i,
    input  logic [1:0]    mode_i,
    output logic [PW-1:0] sh_o
);
    always_comb begin
        case (mode_i)
            2'd0:    sh_o = p_i;
            2'd1:    sh_o = p_i << SL1;
            2'd2:    sh_o = p_i << SL2;
            default: sh_o = $unsigned($signed(p_i) >>> SR);
        endcase
    end

    // R7: right-shift mode replicates the sign into the top SR+1 bits
    always_comb begin
        if (mode_i == 2'd3) begin
            assert_rshift_sign_R7: assert (sh_o[PW-1:PW-SR-1] == {(SR+1){p_i[PW-1]}});
        end
    end

endmodule

// File: rtl/tpm_accum.sv
module tpm_accum
    import tpm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] acc_i,
    input  logic [AW-1:0] x_i,
    input  acc_fn_e       fn_i,
    input  logic          sat_en_i,
    input  logic          carry_i,
    output logic [AW-1:0] res_o,
    output logic          carry_o
);
    localparam logic [AW-1:0] POS_MAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] NEG_MIN = {1'b1, {(AW-1){1'b0}}};

    logic [AW:0]   sum_w;
    logic [AW-1:0] raw;
    logic          ovf;

    always_comb begin
        sum_w   = '0;
        raw     = acc_i;
        ovf     = 1'b0;
        res_o   = acc_i;
        carry_o = carry_i;
        case (fn_i)
            ACC_ADD: begin
                sum_w   = {1'b0, acc_i} + {1'b0, x_i};
                raw     = sum_w[AW-1:0];
                ovf     = (acc_i[AW-1] == x_i[AW-1]) && (raw[AW-1] != acc_i[AW-1]);
                carry_o = sum_w[AW];
                res_o   = (sat_en_i && ovf) ? (acc_i[AW-1] ? NEG_MIN : POS_MAX) : raw;
            end
            ACC_SUB: begin
                sum_w   = {1'b0, acc_i} + {1'b0, ~x_i} + {{AW{1'b0}}, 1'b1};
                raw     = sum_w[AW-1:0];
                ovf     = (acc_i[AW-1] != x_i[AW-1]) && (raw[AW-1] != acc_i[AW-1]);
                carry_o = sum_w[AW];
                res_o   = (sat_en_i && ovf) ? (acc_i[AW-1] ? NEG_MIN : POS_MAX) : raw;
            end
            ACC_MOV: res_o = x_i;
            default: ;
        endcase
    end

    // R10: saturated sum of two non-negative values never turns negative
    always_comb begin
        if (sat_en_i && fn_i == ACC_ADD && !acc_i[AW-1] && !x_i[AW-1]) begin
            assert_sat_sign_R10: assert (!res_o[AW-1]);
        end
    end

endmodule

// File: rtl/tp_mul_unit.sv
module tp_mul_unit
    import tpm_pkg::*;
#(
    parameter int DW   = 16,
    parameter int IMMW = 13,
    parameter int SL1  = 1,
    parameter int SL2  = 4,
    parameter int SR   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic [15:0]   opnd_i,
    input  logic [31:0]   acc_i,
    input  logic          sat_en_i,
    output logic [31:0]   acc_o,
    output logic          acc_we_o,
    output logic          carry_o,
    output logic [15:0]   treg_o,
    output logic [31:0]   preg_o,
    output logic [1:0]    pmode_o
);
    localparam int PW = 2 * DW;

    typedef struct packed {
        logic [DW-1:0] t;
        logic [PW-1:0] p;
        logic [1:0]    pm;
        logic [PW-1:0] acc;
        logic          we;
        logic          cy;
    } st_t;

    st_t           st_q, st_d;
    tpm_ctl_t      ctl;
    logic [DW-1:0] imm_x;
    logic [DW-1:0] fa, fb;
    logic [PW-1:0] prod;
    logic [PW-1:0] psh;
    logic [PW-1:0] acc_res;
    logic          acc_cy;

    always_comb begin
        ctl   = tpm_decode(op_i);
        imm_x = {{(DW-IMMW){opnd_i[IMMW-1]}}, opnd_i[IMMW-1:0]};
        fa    = ctl.sq  ? opnd_i : st_q.t;
        fb    = ctl.imm ? imm_x  : opnd_i;
    end

    tpm_mult #(.DW(DW)) u_mult (
        .a_i   (fa),
        .b_i   (fb),
        .uns_i (ctl.uns),
        .p_o   (prod)
    );

    tpm_pshift #(.PW(PW), .SL1(SL1), .SL2(SL2), .SR(SR)) u_pshift (
        .p_i    (st_q.p),
        .mode_i (st_q.pm),
        .sh_o   (psh)
    );

    tpm_accum #(.AW(PW)) u_accum (
        .acc_i    (acc_i),
        .x_i      (psh),
        .fn_i     (ctl.acc),
        .sat_en_i (sat_en_i),
        .carry_i  (st_q.cy),
        .res_o    (acc_res),
        .carry_o  (acc_cy)
    );

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (ctl.ld_t)   st_d.t  = opnd_i;
        if (ctl.wr_p)   st_d.p  = prod;
        if (ctl.set_pm) st_d.pm = opnd_i[1:0];
        if (ctl.acc != ACC_NONE) begin
            st_d.acc = acc_res;
            st_d.we  = 1'b1;
            st_d.cy  = acc_cy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o    = st_q.acc;
    assign acc_we_o = st_q.we;
    assign carry_o  = st_q.cy;
    assign treg_o   = st_q.t;
    assign preg_o   = st_q.p;
    assign pmode_o  = st_q.pm;

    // R9: strobe follows an accumulating op by one cycle
    assert_we_after_acc_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.acc != ACC_NONE) |=> acc_we_o);

    // R9: non-accumulating op leaves no strobe and keeps the result
    assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.acc == ACC_NONE) |=> (!acc_we_o && $stable(acc_o)));

    // R2: temporary register takes the operand on a loading op
    assert_t_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ld_t |=> (treg_o == $past(opnd_i)));

    // R2: temporary register holds otherwise
    assert_t_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.ld_t |=> $stable(treg_o));

    // R12: product register holds on ops that do not multiply
    assert_p_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.wr_p |=> $stable(preg_o));

    // R8: shift mode changes only through its setting op
    assert_pm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 4'd15) |=> $stable(pmode_o));

    // R11: moves leave the carry untouched
    assert_mov_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.acc == ACC_MOV) |=> $stable(carry_o));

endmodule

// File: tb/tp_mul_unit_bench.sv
`timescale 1ns/1ps
module tp_mul_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [15:0] opnd_i = '0;
    logic [31:0] acc_i = '0;
    logic        sat_en_i = 1'b0;
    logic [31:0] acc_o;
    logic        acc_we_o;
    logic        carry_o;
    logic [15:0] treg_o;
    logic [31:0] preg_o;
    logic [1:0]  pmode_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [15:0] m_t = '0;
    logic [31:0] m_p = '0;
    logic [1:0]  m_pm = '0;
    logic [31:0] m_acc = '0;
    logic        m_we = 1'b0;
    logic        m_cy = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tp_mul_unit u_tp_mul_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opnd_i(opnd_i),
        .acc_i(acc_i), .sat_en_i(sat_en_i), .acc_o(acc_o),
        .acc_we_o(acc_we_o), .carry_o(carry_o), .treg_o(treg_o),
        .preg_o(preg_o), .pmode_o(pmode_o)
    );

    function automatic logic [31:0] f_shift(input logic [31:0] p, input logic [1:0] m);
        longint v;
        v = longint'($signed(p));
        case (m)
            2'd0: return p;
            2'd1: return p << 1;
            2'd2: return p << 4;
            default: begin
                v = v / 64;
                if (longint'($signed(p)) < 0 && (p[5:0] != 6'd0)) v = v - 1;
                return v[31:0];
            end
        endcase
    endfunction

    function automatic logic [31:0] f_mul(input logic [15:0] a, input logic [15:0] b, input bit uns);
        longint r;
        if (uns) r = longint'(a) * longint'(b);
        else     r = longint'($signed(a)) * longint'($signed(b));
        return r[31:0];
    endfunction

    function automatic logic [31:0] f_addsub(input logic [31:0] a, input logic [31:0] x,
                                             input bit sub, input bit sat);
        longint r;
        r = sub ? longint'($signed(a)) - longint'($signed(x))
                : longint'($signed(a)) + longint'($signed(x));
        if (sat && r > 64'sd2147483647)  return 32'h7FFFFFFF;
        if (sat && r < -64'sd2147483648) return 32'h80000000;
        return r[31:0];
    endfunction

    function automatic logic f_carry(input logic [31:0] a, input logic [31:0] x, input bit sub);
        logic [63:0] s;
        if (sub) return (a >= x);
        s = {32'd0, a} + {32'd0, x};
        return s[32];
    endfunction

    function automatic string f_tag(input logic [3:0] op);
        case (op)
            4'd1:              return "R2";
            4'd5, 4'd6:        return "R3";
            4'd9:              return "R4";
            4'd10, 4'd11:      return "R5";
            4'd7, 4'd8:        return "R6";
            4'd15:             return "R8";
            4'd12, 4'd13:      return "R11";
            4'd0:              return "R12";
            default:           return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic [15:0] d, input logic [31:0] a,
                          input bit sat, input string tag_in);
        logic [15:0] e_t;  logic [31:0] e_p;  logic [1:0] e_pm;
        logic [31:0] e_acc; logic e_we; logic e_cy; logic [31:0] sh;
        logic [15:0] imm;  string tag;
        tag  = (tag_in == "") ? f_tag(op) : tag_in;
        sh   = f_shift(m_p, m_pm);
        imm  = {{3{d[12]}}, d[12:0]};
        e_t = m_t; e_p = m_p; e_pm = m_pm; e_acc = m_acc; e_we = 1'b0; e_cy = m_cy;
        case (op)
            4'd1: e_t = d;
            4'd2: begin e_t = d; e_acc = f_addsub(a, sh, 0, sat); e_cy = f_carry(a, sh, 0); e_we = 1; end
            4'd3: begin e_t = d; e_acc = f_addsub(a, sh, 1, sat); e_cy = f_carry(a, sh, 1); e_we = 1; end
            4'd4: begin e_t = d; e_acc = sh; e_we = 1; end
            4'd5: e_p = f_mul(m_t, d, 0);
            4'd6: e_p = f_mul(m_t, imm, 0);
            4'd7: begin e_p = f_mul(m_t, d, 0); e_acc = f_addsub(a, sh, 0, sat); e_cy = f_carry(a, sh, 0); e_we = 1; end
            4'd8: begin e_p = f_mul(m_t, d, 0); e_acc = f_addsub(a, sh, 1, sat); e_cy = f_carry(a, sh, 1); e_we = 1; end
            4'd9: e_p = f_mul(m_t, d, 1);
            4'd10: begin e_t = d; e_p = f_mul(d, d, 0); e_acc = f_addsub(a, sh, 0, sat); e_cy = f_carry(a, sh, 0); e_we = 1; end
            4'd11: begin e_t = d; e_p = f_mul(d, d, 0); e_acc = f_addsub(a, sh, 1, sat); e_cy = f_carry(a, sh, 1); e_we = 1; end
            4'd12: begin e_acc = f_addsub(a, sh, 0, sat); e_cy = f_carry(a, sh, 0); e_we = 1; end
            4'd13: begin e_acc = f_addsub(a, sh, 1, sat); e_cy = f_carry(a, sh, 1); e_we = 1; end
            4'd14: begin e_acc = sh; e_we = 1; end
            4'd15: e_pm = d[1:0];
            default: ;
        endcase
        @(negedge clk);
        op_i = op; opnd_i = d; acc_i = a; sat_en_i = sat;
        @(posedge clk);
        #2;
        chk(tag, "treg", 64'(treg_o), 64'(e_t));
        chk(tag, "preg", 64'(preg_o), 64'(e_p));
        chk(tag, "pmode", 64'(pmode_o), 64'(e_pm));
        chk(tag, "acc/we/carry", {30'd0, acc_we_o, carry_o, acc_o}, {30'd0, e_we, e_cy, e_acc});
        m_t = e_t; m_p = e_p; m_pm = e_pm; m_acc = e_acc; m_we = e_we; m_cy = e_cy;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "treg", 64'(treg_o), 64'd0);
        chk("R1", "preg", 64'(preg_o), 64'd0);
        chk("R1", "pmode/acc/we/carry", {28'd0, pmode_o, acc_we_o, carry_o, acc_o}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 basic signed multiply, R9 move
        run_op(4'd15, 16'h0000, 32'h0, 0, "R8");
        run_op(4'd1,  16'h7FFF, 32'h0, 0, "R2");
        run_op(4'd5,  16'h7FFF, 32'h0, 0, "R3");
        run_op(4'd14, 16'h0000, 32'h12345678, 0, "R9");
        run_op(4'd0,  16'hABCD, 32'h0, 0, "R12");
        // R7 every shift mode
        for (int m = 1; m < 4; m++) begin
            run_op(4'd15, 16'(m) | 16'hFFFC, 32'h0, 0, "R8");
            run_op(4'd14, 16'h0000, 32'h0, 0, "R7");
        end
        run_op(4'd1,  16'h8001, 32'h0, 0, "R2");
        run_op(4'd5,  16'h7FFF, 32'h0, 0, "R7");
        run_op(4'd14, 16'h0000, 32'h0, 0, "R7");
        run_op(4'd15, 16'h0000, 32'h0, 0, "R8");
        // R3 immediate form sign extension
        run_op(4'd1,  16'h0003, 32'h0, 0, "R2");
        run_op(4'd6,  16'hF000, 32'h0, 0, "R3");
        run_op(4'd6,  16'h0FFF, 32'h0, 0, "R3");
        // R4 unsigned extreme
        run_op(4'd1,  16'hFFFF, 32'h0, 0, "R2");
        run_op(4'd9,  16'hFFFF, 32'h0, 0, "R4");
        // R5/R6 square with previous product accumulated
        run_op(4'd10, 16'h8000, 32'h00000010, 0, "R5");
        run_op(4'd11, 16'h0003, 32'h00000000, 0, "R6");
        run_op(4'd7,  16'h0002, 32'h00000100, 0, "R6");
        // R10 saturation and wrap
        run_op(4'd10, 16'h8000, 32'h0, 0, "R5");
        run_op(4'd12, 16'h0000, 32'h7FFFFFFF, 1, "R10");
        run_op(4'd12, 16'h0000, 32'h7FFFFFFF, 0, "R10");
        run_op(4'd13, 16'h0000, 32'h80000000, 1, "R10");
        run_op(4'd13, 16'h0000, 32'h80000000, 0, "R10");
        // R11 carry on add, held on move, no-borrow on subtract
        run_op(4'd12, 16'h0000, 32'hC0000000, 0, "R11");
        run_op(4'd14, 16'h0000, 32'h0, 0, "R11");
        run_op(4'd13, 16'h0000, 32'h00000001, 0, "R11");
        run_op(4'd13, 16'h0000, 32'hF0000000, 0, "R11");

        // random mix
        for (int i = 0; i < 600; i++) begin
            run_op(4'($urandom_range(0, 15)), 16'($urandom), 32'($urandom),
                   1'($urandom_range(0, 1)), "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule